// File: doc/BRIEF.md
# Single-Level Interrupt Return Unit

This unit gives a 32-bit core without a privileged trap system one level of interrupt handling. The core reports each instruction completion with a retire strobe. With that strobe it also reports the address of the following instruction and a small decoded operation code for the retiring instruction. The unit samples a level-sensitive interrupt request only at those retire points. When the request is accepted, the unit stores the following-instruction address in a hidden return register, clears its enable flag and, one cycle later, asks the core to fetch from a fixed vector.

Four decoded operations let software work with the unit. A return operation sends fetch back to the stored address and turns the enable back on. A read operation places the hidden register on a data output. Two further operations set or clear the enable flag. A handler can copy the return address out and then re-enable interrupts, which lets a second interrupt nest inside the first.

Top module: `irq_unit`

## Requirements
- R1: After reset the enable flag is off and the hidden register holds zero. `redirect_valid` is low, a read returns zero, and a retire with the request high does not start an interrupt.
- R2: The request is looked at only in a cycle where `retire_stb` is high. With `retire_stb` low, no redirect follows, whatever the request level is.
- R3: A retire with the request high, the enable on and an operation other than return starts an interrupt. In the next cycle `redirect_valid` is high and `redirect_pc` equals the vector parameter.
- R4: When an interrupt starts, the hidden register takes the `next_pc` value presented with that retire.
- R5: Starting an interrupt turns the enable off. Later retires with the request still high cause no redirect until the enable is turned on again.
- R6: The return operation (`op_sel` = 1) causes, in the next cycle, a redirect to the value the hidden register held at that retire. It also turns the enable on.
- R7: The retire of a return never starts an interrupt itself. When the request is still high, the next retire after the return starts one and stores that retire's `next_pc`, so at least one instruction runs between the two interrupts.
- R8: The set operation (`op_sel` = 3) turns the enable on and the clear operation (`op_sel` = 4) turns it off. The change applies from the following retire onward. When an interrupt starts on the same retire as a set, the interrupt wins and the enable ends up off.
- R9: With `op_sel` = 2, `rd_data` shows the hidden register (combinational, with or without a retire). For any other value `rd_data` is zero. The values 0 and 5 to 7 are ordinary instructions.
- R10: `redirect_valid` stays high for one cycle per event. The two low bits of `redirect_pc` are always zero, because the vector is forced to a 4-byte boundary.
- R11: An `op_sel` value presented while `retire_stb` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Level interrupt request |
| retire_stb | input | 1 | An instruction completes this cycle |
| next_pc | input | 32 | Address of the instruction after the retiring one |
| op_sel | input | 3 | Decoded operation of the retiring instruction |
| redirect_valid | output | 1 | Fetch override request, one cycle |
| redirect_pc | output | 32 | Fetch override address |
| rd_data | output | 32 | Hidden register value for the read operation |

## Verification
The redirect and all state changes are registered. Each is therefore due one clock edge after the retire that causes it, while `rd_data` follows `op_sel` in the same cycle. The bench changes its inputs on a falling edge and lets one rising edge pass. It checks the redirect outputs on the next falling edge, before it drives anything new. It checks reads a short delay after setting `op_sel`, with the strobe low. An "ignored" stimulus is shown to have no effect by watching the redirect outputs at the next retire, or by reading the hidden register.

// File: rtl/irq_pkg.sv
// Shared encoding of the decoded operation code that the core passes with each retire.
package irq_pkg;
    typedef enum logic [2:0] {
        OP_PLAIN  = 3'd0,
        OP_RETURN = 3'd1,
        OP_READ   = 3'd2,
        OP_IE_SET = 3'd3,
        OP_IE_CLR = 3'd4
    } irq_op_e;
endpackage

// File: rtl/irq_opdec.sv
// Decodes the operation code into strobes.
// Assumes: state-changing strobes are valid only together with retire_stb;
// the read strobe follows op_sel alone (R9, R11).
module irq_opdec
    import irq_pkg::*;
(
    input  logic       retire_i,
    input  logic [2:0] op_i,
    output logic       ret_o,
    output logic       set_o,
    output logic       clr_o,
    output logic       read_o
);
    // Compare the code against each operation and qualify with retire.
    always_comb begin
        ret_o  = retire_i && (op_i == OP_RETURN);
        set_o  = retire_i && (op_i == OP_IE_SET);
        clr_o  = retire_i && (op_i == OP_IE_CLR);
        read_o = (op_i == OP_READ);
    end
endmodule

// File: rtl/irq_enable.sv
// Holds the interrupt enable flag.
// Assumes: take_i has the highest priority and forces the flag off (R5, R8).
module irq_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic ret_i,
    input  logic set_i,
    input  logic clr_i,
    output logic ie_o
);
    // Update the enable flag: take, then return/set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              ie_o <= 1'b0;
        else if (take_i)         ie_o <= 1'b0;
        else if (ret_i || set_i) ie_o <= 1'b1;
        else if (clr_i)          ie_o <= 1'b0;
    end
endmodule

// File: rtl/irq_retreg.sv
// Hidden return register; loads the following-instruction address when an
// interrupt starts. Assumes pc_i is valid whenever take_i is high.
module irq_retreg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] saved_o
);
    // Capture the return address on an accepted interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)      saved_o <= '0;
        else if (take_i) saved_o <= pc_i;
    end
endmodule

// File: rtl/irq_redirect.sv
// Decides when to start an interrupt and registers the fetch override.
// Assumes: the decision uses the enable value from before this retire,
// and a retiring return never starts an interrupt (R7).
module irq_redirect #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_i,
    input  logic            irq_i,
    input  logic            ie_i,
    input  logic            ret_i,
    input  logic [XLEN-1:0] saved_i,
    output logic            take_o,
    output logic            valid_o,
    output logic [XLEN-1:0] pc_o
);
    localparam logic [XLEN-1:0] VEC_ALIGNED = {VEC_ADDR[XLEN-1:2], 2'b00};

    // Accept the request only at a retire while the enable is on.
    always_comb take_o = retire_i && irq_i && ie_i && !ret_i;

    // Register a one-cycle override toward the vector or the return address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            pc_o    <= '0;
        end else if (take_o) begin
            valid_o <= 1'b1;
            pc_o    <= VEC_ALIGNED;
        end else if (ret_i) begin
            valid_o <= 1'b1;
            pc_o    <= {saved_i[XLEN-1:2], 2'b00};
        end else begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_unit.sv
// Top of the single-level interrupt unit: joins the decoder, enable flag,
// hidden register and redirect logic. Assumes one retire per cycle at most.
module irq_unit #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic            retire_stb,
    input  logic [XLEN-1:0] next_pc,
    input  logic [2:0]      op_sel,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] rd_data
);
    logic            ret_w, set_w, clr_w, read_w;
    logic            take_w, ie_q;
    logic [XLEN-1:0] saved_q;

    irq_opdec u_dec (
        .retire_i (retire_stb),
        .op_i     (op_sel),
        .ret_o    (ret_w),
        .set_o    (set_w),
        .clr_o    (clr_w),
        .read_o   (read_w)
    );

    irq_enable u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_w),
        .ret_i  (ret_w),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .ie_o   (ie_q)
    );

    irq_retreg #(.XLEN(XLEN)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_w),
        .pc_i    (next_pc),
        .saved_o (saved_q)
    );

    irq_redirect #(.XLEN(XLEN), .VEC_ADDR(VEC_ADDR)) u_rdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire_i (retire_stb),
        .irq_i    (irq_req),
        .ie_i     (ie_q),
        .ret_i    (ret_w),
        .saved_i  (saved_q),
        .take_o   (take_w),
        .valid_o  (redirect_valid),
        .pc_o     (redirect_pc)
    );

    // Drive the hidden register onto the read port for the read operation only.
    always_comb rd_data = read_w ? saved_q : '0;
endmodule

// File: rtl/irq_unit_chk.sv
// Checker for irq_unit, attached with bind; it sees ports and a few internal nets.
module irq_unit_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_ADDR = 32'h0000_0010
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic            retire_stb,
    input logic [XLEN-1:0] next_pc,
    input logic [2:0]      op_sel,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] rd_data,
    input logic            ie_state,
    input logic [XLEN-1:0] saved,
    input logic            take
);
    localparam logic [XLEN-1:0] VEC_CHK = {VEC_ADDR[XLEN-1:2], 2'b00};

    a_r2_no_retire_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_stb |=> !redirect_valid);
    a_r3_take_to_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (redirect_valid && redirect_pc == VEC_CHK));
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (saved == $past(next_pc)));
    a_r5_auto_disable: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ie_state);
    a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_state |-> !take);
    a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_stb && op_sel == 3'd1) |=>
            (redirect_valid && redirect_pc == $past(saved) && ie_state));
    a_r7_return_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_stb && op_sel == 3'd1) |-> !take);
    a_r9_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 3'd2) |-> (rd_data == '0));
    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc[1:0] == 2'b00));
endmodule

bind irq_unit irq_unit_chk #(.XLEN(XLEN), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_req        (irq_req),
    .retire_stb     (retire_stb),
    .next_pc        (next_pc),
    .op_sel         (op_sel),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .rd_data        (rd_data),
    .ie_state       (ie_q),
    .saved          (saved_q),
    .take           (take_w)
);

// File: tb/tb_irq_unit.sv
// Directed bench for irq_unit: one task per scenario, each checking itself.
module tb_irq_unit;
    localparam logic [31:0] VEC = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        retire_stb = 1'b0;
    logic [31:0] next_pc = '0;
    logic [2:0]  op_sel = 3'd0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_unit #(.XLEN(32), .VEC_ADDR(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .retire_stb(retire_stb),
        .next_pc(next_pc), .op_sel(op_sel), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one cycle of inputs at a falling edge; return at the next falling edge.
    task automatic step(input logic r, input logic [2:0] op, input logic [31:0] pc);
        retire_stb = r; op_sel = op; next_pc = pc;
        @(negedge clk);
        retire_stb = 1'b0; op_sel = 3'd0;
    endtask

    task automatic read_chk(input string req, input logic [31:0] exp);
        op_sel = 3'd2; #1;
        chk(req, rd_data, exp);
        op_sel = 3'd0; #1;
    endtask

    task automatic t_reset;
        chk("R1 redirect idle", {31'd0, redirect_valid}, 32'd0);
        read_chk("R1 hidden zero", 32'd0);
        irq_req = 1'b1;
        step(1'b1, 3'd0, 32'h40);
        chk("R1 disabled after reset", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic t_retire_only;
        step(1'b1, 3'd3, 32'h44);
        chk("R8 set applies next retire", {31'd0, redirect_valid}, 32'd0);
        for (int i = 0; i < 5; i++) step(1'b0, 3'd0, 32'h0);
        chk("R2 no retire no take", {31'd0, redirect_valid}, 32'd0);
        step(1'b0, 3'd4, 32'h0);
        chk("R11 clear without retire", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic t_take;
        step(1'b1, 3'd0, 32'h100);
        chk("R3 redirect valid", {31'd0, redirect_valid}, 32'd1);
        chk("R3 vector", redirect_pc, VEC);
        chk("R10 aligned", {30'd0, redirect_pc[1:0]}, 32'd0);
        step(1'b0, 3'd0, 32'h0);
        chk("R10 single pulse", {31'd0, redirect_valid}, 32'd0);
        read_chk("R4 saved next_pc", 32'h100);
    endtask

    task automatic t_masked;
        step(1'b1, 3'd0, 32'h104);
        chk("R5 masked 1", {31'd0, redirect_valid}, 32'd0);
        step(1'b1, 3'd0, 32'h108);
        chk("R5 masked 2", {31'd0, redirect_valid}, 32'd0);
        read_chk("R5 saved kept", 32'h100);
    endtask

    task automatic t_return;
        step(1'b1, 3'd1, 32'h10C);
        chk("R6 return valid", {31'd0, redirect_valid}, 32'd1);
        chk("R6 return target", redirect_pc, 32'h100);
        step(1'b0, 3'd0, 32'h0);
        chk("R7 no take on return", {31'd0, redirect_valid}, 32'd0);
        step(1'b1, 3'd0, 32'h104);
        chk("R7 retake after one instr", redirect_pc, VEC);
        chk("R7 retake valid", {31'd0, redirect_valid}, 32'd1);
        read_chk("R7 saved progress", 32'h104);
    endtask

    task automatic t_enable_ops;
        irq_req = 1'b0;
        step(1'b1, 3'd1, 32'h0);
        chk("R6 return target 2", redirect_pc, 32'h104);
        step(1'b1, 3'd4, 32'h108);
        irq_req = 1'b1;
        step(1'b1, 3'd0, 32'h10C);
        chk("R8 clear masks", {31'd0, redirect_valid}, 32'd0);
        step(1'b1, 3'd3, 32'h110);
        chk("R8 set not same retire", {31'd0, redirect_valid}, 32'd0);
        step(1'b1, 3'd5, 32'h114);
        chk("R9 code 5 plain, take", redirect_pc, VEC);
        chk("R9 code 5 valid", {31'd0, redirect_valid}, 32'd1);
        read_chk("R9 read saved", 32'h114);
        op_sel = 3'd7; #1;
        chk("R9 other code reads zero", rd_data, 32'd0);
        op_sel = 3'd0; #1;
    endtask

    task automatic t_take_over_set;
        step(1'b1, 3'd3, 32'h200);
        chk("R8 set while disabled", {31'd0, redirect_valid}, 32'd0);
        step(1'b1, 3'd3, 32'h204);
        chk("R8 take on set retire", {31'd0, redirect_valid}, 32'd1);
        read_chk("R8 saved 204", 32'h204);
        step(1'b1, 3'd0, 32'h208);
        chk("R8 take beats set", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_retire_only();
        t_take();
        t_masked();
        t_return();
        t_enable_ops();
        t_take_over_set();
        finish_run();
    end
endmodule